// File: doc/BRIEF.md
# Windowed Byte-Register Access Bridge

This block lets a host reach a bank of 256 byte-wide internal registers through one 32-bit window word. The host stores a packed command into the window. The command holds an 8-bit register address, a byte of write data and a direction flag. The bridge captures the command and performs one access on an internal byte port that has a fixed read latency. While that access is under way, a busy flag in the window stays set.

A write is complete after a single window store. A read takes two steps. The host first stores the address with the direction flag clear. It then reads the window repeatedly until busy drops, and takes the byte from the top of the word. A plain byte memory stands in for the internal registers. Reading the window is a pure observation: there is no read-strobe input, so a read cannot start an access.

Top module: `win_reg_bridge`

## Requirements
- R1: After reset the window reads as all zeros, busy is clear and every internal register holds 0x00.
- R2: An accepted window store latches address from bits [7:0], data from bits [15:8] and direction from bit 16. Reading the window returns these in the same positions, and bits [22:17] always read zero.
- R3: Busy (bit 23) rises in the cycle after an accepted store and stays high for exactly BUSY_CYCLES cycles (4 by default).
- R4: A store with bit 16 = 0 reads the addressed register, whose byte appears in bits [31:24] once busy has cleared.
- R5: A store with bit 16 = 1 writes bits [15:8] into the addressed register, and a later read returns that byte. A write access leaves bits [31:24] unchanged.
- R6: A store that arrives while busy is set is ignored. It leaves the latched fields unchanged and causes no internal access.
- R7: Bits [31:24] change only in the cycle busy falls. During a read they keep the previous result.
- R8: The internal registers are independent across the whole address range, including 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host stores hostWrData into the window this cycle |
| hostWrData | input | 32 | Window command word; bits above 16 are ignored |
| hostRdData | output | 32 | Current window contents: fields, busy, read byte |

## Verification
Several patterns are tried: writes of complementary bytes (0x5A, 0xA5) at the two end addresses and at a middle address, each followed by a read-back. These separate a correct address decode from bits that are stuck or swapped. A read of a register that has never been written must return zero, which separates real storage from a stale result. A read issued straight after another read with a different value shows whether the result byte is updated too early, that is, before busy falls. A store issued during busy, to an address that is then read, shows whether ignored commands leak into the bank or into the window fields.

// File: rtl/win_bridge_pkg.sv
package win_bridge_pkg;
  localparam int WIN_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int REG_COUNT  = 1 << BYTE_W;
  localparam int DIR_BIT    = 16;
  localparam int BUSY_BIT   = 23;
  localparam int RDATA_LSB  = 24;

  typedef struct packed {
    logic accept;  // window command captured this edge
    logic issue;   // internal access presented this cycle
    logic finish;  // busy drops at this edge
  } winStrobe_t;
endpackage

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_bridge_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  output winStrobe_t strb,
  output logic       busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          issueQ;

  always_comb begin
    strb.accept = hostWrEn && !busy;
    strb.issue  = issueQ;
    strb.finish = busy && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      issueQ <= 1'b0;
    end else begin
      issueQ <= strb.accept;
      if (strb.accept) begin
        busy <= 1'b1;
        cnt  <= CW'(BUSY_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/win_datapath.sv
module win_datapath
  import win_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strb,
  input  logic              busy,
  input  logic [WIN_W-1:0]  hostWrData,
  input  logic [BYTE_W-1:0] bankRdata,
  output logic              bankReq,
  output logic              bankWe,
  output logic [BYTE_W-1:0] bankAddr,
  output logic [BYTE_W-1:0] bankWdata,
  output logic [WIN_W-1:0]  window
);
  logic [BYTE_W-1:0] addrQ;
  logic [BYTE_W-1:0] wdataQ;
  logic              dirQ;
  logic [BYTE_W-1:0] rdByte;
  logic              unusedHiBits;

  assign unusedHiBits = ^hostWrData[WIN_W-1:DIR_BIT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      dirQ   <= 1'b0;
      rdByte <= '0;
    end else begin
      if (strb.accept) begin
        addrQ  <= hostWrData[BYTE_W-1:0];
        wdataQ <= hostWrData[2*BYTE_W-1:BYTE_W];
        dirQ   <= hostWrData[DIR_BIT];
      end
      if (strb.finish && !dirQ) rdByte <= bankRdata;
    end
  end

  assign bankReq   = strb.issue;
  assign bankWe    = dirQ;
  assign bankAddr  = addrQ;
  assign bankWdata = wdataQ;

  always_comb begin
    window                            = '0;
    window[BYTE_W-1:0]                = addrQ;
    window[2*BYTE_W-1:BYTE_W]         = wdataQ;
    window[DIR_BIT]                   = dirQ;
    window[BUSY_BIT]                  = busy;
    window[WIN_W-1:RDATA_LSB]         = rdByte;
  end
endmodule

// File: rtl/reg_bank_model.sv
module reg_bank_model
  import win_bridge_pkg::*;
#(
  parameter int RD_LATENCY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem  [REG_COUNT];
  logic [BYTE_W-1:0] pipe [RD_LATENCY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else if (req && we) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else if (req && !we) pipe[0] <= mem[addr];
  end

  for (genvar s = 1; s < RD_LATENCY; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign rdata = pipe[RD_LATENCY-1];
endmodule

// File: rtl/win_reg_bridge.sv
module win_reg_bridge
  import win_bridge_pkg::*;
#(
  parameter int RD_LATENCY = 2,
  parameter int BUSY_SLACK = 2  // at least 1: busy outlasts the read pipe
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData
);
  localparam int BUSY_CYCLES = RD_LATENCY + BUSY_SLACK;

  winStrobe_t        strb;
  logic              busy;
  logic              bankReq;
  logic              bankWe;
  logic [BYTE_W-1:0] bankAddr;
  logic [BYTE_W-1:0] bankWdata;
  logic [BYTE_W-1:0] bankRdata;

  win_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .strb(strb), .busy(busy)
  );

  win_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .hostWrData(hostWrData), .bankRdata(bankRdata),
    .bankReq(bankReq), .bankWe(bankWe), .bankAddr(bankAddr),
    .bankWdata(bankWdata), .window(hostRdData)
  );

  reg_bank_model #(.RD_LATENCY(RD_LATENCY)) u_bank (
    .clk(clk), .rstN(rstN), .req(bankReq), .we(bankWe),
    .addr(bankAddr), .wdata(bankWdata), .rdata(bankRdata)
  );
endmodule

// File: rtl/win_bridge_chk.sv
module win_bridge_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [31:0] window,
  input logic        bankReq
);
  localparam int RW = $clog2(BUSY_CYCLES + 2);

  logic          busyW;
  logic [RW-1:0] runCnt;

  assign busyW = window[23];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          runCnt <= '0;
    else if (!busyW)                    runCnt <= '0;
    else if (runCnt != RW'(BUSY_CYCLES + 1)) runCnt <= runCnt + 1'b1;
  end

  // R3: busy begins only after a store and lasts exactly BUSY_CYCLES
  a_r3_rise_after_store: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyW) |-> $past(hostWrEn));
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RW'(BUSY_CYCLES));
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyW) |-> runCnt == RW'(BUSY_CYCLES));
  // R6: stores during busy leave the fields alone; accesses only at start
  a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busyW && hostWrEn) |=> window[16:0] == $past(window[16:0]));
  a_r6_req_on_start: assert property (@(posedge clk) disable iff (!rstN)
    bankReq |-> $rose(busyW));
  // R7: result byte moves only when busy falls
  a_r7_rd_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (window[31:24] != $past(window[31:24])) |-> $fell(busyW));
  // R2: reserved bits are zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    window[22:17] == 6'd0);
endmodule

bind win_reg_bridge win_bridge_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn),
  .window(hostRdData), .bankReq(bankReq)
);

// File: tb/tb_win_reg_bridge.sv
module tb_win_reg_bridge;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  win_reg_bridge dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] a, input logic [7:0] d,
                                      input bit wr);
    return {15'd0, wr, d, a};
  endfunction

  task automatic store(input logic [31:0] w);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrData = w;
    @(negedge clk);
    hostWrEn   = 1'b0;
    hostWrData = '0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 50 && hostRdData[23]; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    store(cmd(a, d, 1'b1));
    waitIdle();
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    store(cmd(a, 8'h00, 1'b0));
    waitIdle();
    d = hostRdData[31:24];
  endtask

  task automatic tReset();
    chk(hostRdData == 32'h0, "R1 window after reset", hostRdData, 32'h0);
  endtask

  task automatic tResetBank();
    logic [7:0] d;
    regRead(8'h33, d);
    chk(d == 8'h00, "R1 register after reset", {24'd0, d}, 32'h0);
  endtask

  task automatic tFields();
    store(cmd(8'hC3, 8'h96, 1'b1));
    chk(hostRdData[16:0] == 17'h196C3, "R2 latched fields",
        {15'd0, hostRdData[16:0]}, 32'h000196C3);
    chk(hostRdData[22:17] == 6'd0, "R2 reserved bits", {26'd0, hostRdData[22:17]}, 32'h0);
    waitIdle();
  endtask

  task automatic tBusyTiming();
    store(cmd(8'h01, 8'h00, 1'b0));
    for (int i = 0; i < BUSY; i++) begin
      chk(hostRdData[23] == 1'b1, "R3 busy held", {31'd0, hostRdData[23]}, 32'h1);
      @(negedge clk);
    end
    chk(hostRdData[23] == 1'b0, "R3 busy drops", {31'd0, hostRdData[23]}, 32'h0);
  endtask

  task automatic tWriteRead(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    regWrite(a, d);
    regRead(a, r);
    chk(r == d, "R4 R5 read back written byte", {24'd0, r}, {24'd0, d});
  endtask

  task automatic tWriteKeepsRd();
    logic [7:0] r;
    regWrite(8'h50, 8'h6E);
    regRead(8'h50, r);
    regWrite(8'h51, 8'h01);
    chk(hostRdData[31:24] == 8'h6E, "R5 write keeps result byte",
        {24'd0, hostRdData[31:24]}, 32'h6E);
  endtask

  task automatic tHoldDuringRead();
    logic [7:0] r;
    bit held = 1'b1;
    regWrite(8'h20, 8'h11);
    regWrite(8'h21, 8'h99);
    regRead(8'h20, r);
    store(cmd(8'h21, 8'h00, 1'b0));
    while (hostRdData[23]) begin
      if (hostRdData[31:24] != 8'h11) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R7 old result held during busy", {31'd0, held}, 32'h1);
    chk(hostRdData[31:24] == 8'h99, "R7 new result after busy",
        {24'd0, hostRdData[31:24]}, 32'h99);
  endtask

  task automatic tIgnoreWhileBusy();
    logic [7:0] r;
    store(cmd(8'h40, 8'h77, 1'b1));
    store(cmd(8'h41, 8'hEE, 1'b1));
    waitIdle();
    chk(hostRdData[16:0] == 17'h17740, "R6 fields unchanged",
        {15'd0, hostRdData[16:0]}, 32'h00017740);
    regRead(8'h41, r);
    chk(r == 8'h00, "R6 ignored store not written", {24'd0, r}, 32'h0);
  endtask

  task automatic tIndependent();
    logic [7:0] r;
    regWrite(8'h00, 8'h5A);
    regWrite(8'hFF, 8'hA5);
    regWrite(8'h80, 8'h3C);
    regRead(8'h00, r);
    chk(r == 8'h5A, "R8 address 0x00", {24'd0, r}, 32'h5A);
    regRead(8'hFF, r);
    chk(r == 8'hA5, "R8 address 0xFF", {24'd0, r}, 32'hA5);
    regRead(8'h80, r);
    chk(r == 8'h3C, "R8 address 0x80", {24'd0, r}, 32'h3C);
    regRead(8'h7F, r);
    chk(r == 8'h00, "R8 neighbour untouched", {24'd0, r}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tResetBank();
    tFields();
    tBusyTiming();
    tWriteRead(8'h12, 8'h5A);
    tWriteRead(8'h13, 8'hA5);
    tWriteKeepsRd();
    tHoldDuringRead();
    tIgnoreWhileBusy();
    tIndependent();
    doneFlag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule